// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers eight peripheral interrupt request lines and presents one interrupt request to a processor. Each request line is captured in a request register, and the capture holds until the level is acknowledged. A mask register that the processor writes keeps selected lines from interrupting. A fixed-priority resolver picks the pending unmasked level with the lowest index. An in-service register records the levels the processor is currently handling. A new request interrupts only when it outranks every level in that register, so handlers nest strictly by priority.

The processor sees a small register window. It has a 2-bit address, read and write strobes, and an 8-bit data path that is split into an input half and an output half. The output half carries a drive-enable, which a pad-level tristate can use. When the active-low acknowledge input falls, the controller marks the winning level as in service and drops its request. For one cycle it then drives a vector made from a programmable base and the level number. A non-specific end-of-interrupt write retires the highest-priority level in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the request and in-service registers clear to zero, every mask bit is set to one, the vector base clears to zero, and `irq_out` and `data_oe` are low after that edge.
- R2: A request line that is high for a single cycle stays recorded in the request register until that level is acknowledged. Reading address 1 returns the register, with bit k standing for line k.
- R3: A request on a masked line causes no `irq_out`, but it stays recorded in the request register. Address 0 is read and written as the mask, and a one bit masks its line.
- R4: Priority is fixed, and line 0 is the highest. The vector puts the level number in bits 2:0 and the base in bits 7:3. The base is written and read at address 3, and bits 2:0 of that write are ignored.
- R5: The acknowledge is taken on the first cycle that `ack_n` is seen low after being high. In that one clock edge the winning level's in-service bit is set and its request bit is cleared. For exactly the next cycle `data_oe` is high and `data_out` holds the vector.
- R6: `irq_out` is high in a cycle exactly when, at the previous clock edge, some pending unmasked level had a lower index than every set in-service bit.
- R7: Any write to address 1 clears the lowest-index set in-service bit and leaves the other in-service bits unchanged.
- R8: An acknowledge that arrives when no level is eligible changes no register and returns the vector with level 7.
- R9: Holding `ack_n` low for several cycles yields only one vector and one in-service update.
- R10: A read strobe puts the addressed register on `data_out` with `data_oe` high in the following cycle. Address 2 reads the in-service register. A write to address 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Peripheral request lines, active high |
| irq_out | output | 1 | Interrupt request to the processor, registered |
| ack_n | input | 1 | Active-low interrupt acknowledge |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data or vector to the processor |
| data_oe | output | 1 | High when data_out should be driven onto the bus |

## Verification
A corrupted request or mask bit shows up at `irq_out` one cycle after the state goes wrong. It is exposed because `irq_out` is compared with a model after every operation. A wrong in-service bit can stay hidden until the next acknowledge or end-of-interrupt. At that point the vector level or the nesting decision differs from the model, so the bench also reads the in-service and request registers back at regular intervals. An edge detector that fires twice would show as a second vector cycle while the acknowledge is held low.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    REG_MASK    = 2'd0,
    REG_REQ_EOI = 2'd1,
    REG_SERV    = 2'd2,
    REG_BASE    = 2'd3
  } pic_reg_e;
endpackage

// File: rtl/pic_prio_enc.sv
// Returns the lowest set index of a vector (index 0 has highest priority).
module pic_prio_enc #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ack_edge.sv
// Detects the high-to-low transition of the acknowledge strobe.
module pic_ack_edge (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic fire
);
  logic ack_q;
  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b1;
    else     ack_q <= ack_n;
  end
  assign fire = ack_q & ~ack_n;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 irq_out,
  input  logic                 ack_n,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    data_in,
  output logic [DATA_W-1:0]    data_out,
  output logic                 data_oe
);
  import pic_pkg::*;

  localparam int LVL_W  = $clog2(NUM_LINES);
  localparam int BASE_W = DATA_W - LVL_W;
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] mask_q, irr_q, isr_q;
  logic [BASE_W-1:0]    base_q;
  logic [NUM_LINES-1:0] pend, win_oh, eoi_oh, take_oh;
  logic                 pend_any, srv_any, grant_ok, ack_fire, eoi_wr;
  logic [LVL_W-1:0]     win_idx, srv_idx;
  pic_reg_e             reg_sel;

  assign reg_sel = pic_reg_e'(addr);
  assign pend    = irr_q & ~mask_q;

  pic_prio_enc #(.N(NUM_LINES)) u_pend_enc (.vec(pend),  .any(pend_any), .idx(win_idx));
  pic_prio_enc #(.N(NUM_LINES)) u_serv_enc (.vec(isr_q), .any(srv_any),  .idx(srv_idx));
  pic_ack_edge u_ack (.clk(clk), .rst(rst), .ack_n(ack_n), .fire(ack_fire));

  // A pending level is eligible only if it outranks every in-service level.
  assign grant_ok = pend_any && (!srv_any || (win_idx < srv_idx));
  assign win_oh   = NUM_LINES'(1) << win_idx;
  assign take_oh  = (ack_fire && grant_ok) ? win_oh : '0;
  assign eoi_wr   = wr_en && (reg_sel == REG_REQ_EOI);
  assign eoi_oh   = (eoi_wr && srv_any) ? (NUM_LINES'(1) << srv_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      irr_q   <= '0;
      isr_q   <= '0;
      base_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      irr_q   <= (irr_q | irq_in) & ~take_oh;
      isr_q   <= (isr_q & ~eoi_oh) | take_oh;
      irq_out <= grant_ok;
      if (wr_en && reg_sel == REG_MASK) mask_q <= data_in[NUM_LINES-1:0];
      if (wr_en && reg_sel == REG_BASE) base_q <= data_in[DATA_W-1:LVL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else if (ack_fire) begin
      data_out <= {base_q, grant_ok ? win_idx : SPUR_LVL};
      data_oe  <= 1'b1;
    end else if (rd_en) begin
      data_oe <= 1'b1;
      case (reg_sel)
        REG_MASK:    data_out <= DATA_W'(mask_q);
        REG_REQ_EOI: data_out <= DATA_W'(irr_q);
        REG_SERV:    data_out <= DATA_W'(isr_q);
        default:     data_out <= {base_q, {LVL_W{1'b0}}};
      endcase
    end else begin
      data_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ack_n,
  input logic         irq_out,
  input logic         data_oe,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] irr_q,
  input logic [N-1:0] isr_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && irr_q == '0 && isr_q == '0 && !irq_out && !data_oe));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((irr_q & ~mask_q) == '0) |=> !irq_out);

  // R5
  ack_vector_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |=> data_oe);

  // R6
  nest_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(isr_q[0]) |-> !irq_out);

  // R7
  eoi_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1 && isr_q != '0 && ack_n)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

bind prio_irq_ctrl pic_chk #(.N(NUM_LINES)) u_pic_chk (
  .clk(clk), .rst(rst), .ack_n(ack_n), .irq_out(irq_out), .data_oe(data_oe),
  .wr_en(wr_en), .addr(addr), .mask_q(mask_q), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       irq_out;
  logic       ack_n = 1'b1;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] m_mask, m_irr, m_isr;
  logic [4:0] m_base;

  prio_irq_ctrl dut (.*);

  always #5 clk = ~clk;

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int low_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_grant();
    int w = low_idx(m_irr & ~m_mask);
    return (w < 8) && (w < low_idx(m_isr));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; data_in = d;
    tick();
    wr_en = 1'b0;
    if (a == 2'd0) m_mask = d;
    if (a == 2'd3) m_base = d[7:3];
    if (a == 2'd1 && low_idx(m_isr) < 8) m_isr[low_idx(m_isr)] = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    chk(data_oe && data_out == exp, tag, data_out, exp);
  endtask

  task automatic pulse(input logic [7:0] v);
    irq_in = v;
    tick();
    irq_in = '0;
    m_irr = m_irr | v;
  endtask

  task automatic irq_chk(input string tag);
    tick();
    chk(irq_out == m_grant(), tag, irq_out, m_grant());
  endtask

  task automatic ack(input int hold);
    logic [7:0] exp;
    int w;
    w = low_idx(m_irr & ~m_mask);
    if (m_grant()) begin
      exp = {m_base, 3'(w)};
      m_isr[w] = 1'b1;
      m_irr[w] = 1'b0;
    end else begin
      exp = {m_base, 3'd7};
    end
    ack_n = 1'b0;
    tick();
    chk(data_oe && data_out == exp, "R5 R4 R8 vector", data_out, exp);
    for (int i = 1; i < hold; i++) begin
      tick();
      chk(!data_oe, "R9 single vector", data_oe, 0);
    end
    ack_n = 1'b1;
    tick();
    chk(!data_oe, "R5 vector one cycle", data_oe, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_mask = 8'hFF; m_irr = '0; m_isr = '0; m_base = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(!irq_out && !data_oe, "R1 outputs", {irq_out, data_oe}, 0);
    rd_chk(2'd0, 8'hFF, "R1 mask all set");
    rd_chk(2'd1, 8'h00, "R1 request clear");
    rd_chk(2'd2, 8'h00, "R1 in-service clear");

    // R2 / R3: pulse held while masked, no interrupt
    pulse(8'h24);
    irq_chk("R3 masked quiet");
    rd_chk(2'd1, 8'h24, "R2 pulse latched");
    wr(2'd3, 8'hA5);
    rd_chk(2'd3, 8'hA0, "R4 base readback");
    wr(2'd2, 8'hFF);
    rd_chk(2'd2, 8'h00, "R10 addr2 write ignored");
    wr(2'd0, 8'hFB);
    irq_chk("R3 unmasked line 2");
    wr(2'd0, 8'h00);
    irq_chk("R6 line 2 eligible");
    ack(1);  // level 2
    irq_chk("R6 line 5 blocked by 2");
    rd_chk(2'd2, 8'h04, "R5 in-service set");
    rd_chk(2'd1, 8'h20, "R5 request cleared");
    pulse(8'h02);
    irq_chk("R6 line 1 preempts 2");
    ack(4);  // level 1, held low (R9)
    rd_chk(2'd2, 8'h06, "R9 one update");
    wr(2'd1, 8'h00);
    rd_chk(2'd2, 8'h04, "R7 lowest retired");
    wr(2'd1, 8'h00);
    irq_chk("R6 line 5 after EOI");
    wr(2'd0, 8'hFF);
    irq_chk("R3 all masked");
    ack(1);  // spurious, R8
    rd_chk(2'd2, 8'h00, "R8 in-service unchanged");
    rd_chk(2'd1, 8'h20, "R8 request unchanged");
    wr(2'd0, 8'h00);

    // random phase
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 4))
        0: pulse(8'($urandom));
        1: wr(2'd0, 8'($urandom) & 8'($urandom));
        2: ack(1);
        3: wr(2'd1, 8'h00);
        default: wr(2'd3, 8'($urandom));
      endcase
      irq_chk("R6 random irq");
      if (it % 16 == 0) begin
        rd_chk(2'd2, m_isr, "R7 random in-service");
        rd_chk(2'd1, m_irr, "R2 random request");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule